// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Classifier

This block turns two limited square waves into a keypad code. One input carries the low-band tone and the other carries the high-band tone, each already filtered and squared up. Each band has its own tracker. A tracker counts reference-clock cycles from one rising edge to the next and compares the count with four period windows, one for each nominal tone of that band. The window bounds are computed at elaboration from the clock rate, so the hardware needs no divider.

A band becomes valid only after the same window has matched for several periods in a row. A single period that falls outside every window, or a long stretch with no edge, clears the band. The early-steering output is high while both bands are valid. The key code register loads the decoded pair on each clock in which early-steering is high. An inhibit input stops the four letter keys from raising early-steering, so the code keeps its previous value while a letter key is present under inhibit.

Each tracker is a three-state machine:
- `TRK_IDLE`: no reference edge is held yet. Any rising edge moves to `TRK_HUNT`.
- `TRK_HUNT`: each period updates a run of consecutive matches to the same window. A miss sets the run to zero. A match to a different window restarts the run at one. When the run reaches the lock count, the tracker moves to `TRK_LOCK`.
- `TRK_LOCK`: a matching period keeps the lock. A miss or a different window moves back to `TRK_HUNT`.
- From `TRK_HUNT` or `TRK_LOCK`, the silence timeout moves to `TRK_IDLE`.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: A tone within ±(1.5% + 2 Hz) of a nominal frequency is accepted. Nominal frequencies are 697, 770, 852 and 941 Hz for the low band and 1209, 1336, 1477 and 1633 Hz for the high band. Each window covers the integer period counts in [ceil(CLK_HZ/(f·(1+TOL))), floor(CLK_HZ/(f·(1−TOL)))]. TOL = TOL_PM/1000 and defaults to 2.5%.
- R2: A tone that deviates by 3.5% or more from every nominal frequency of its band matches no window.
- R3: The period is the number of clock cycles between successive rising edges. A band becomes valid on the clock edge that completes LOCK_RUN consecutive periods (default 4) in the same window, and not before.
- R4: A single period outside that band's window clears the band's validity on the edge that measures it.
- R5: A band with no rising edge for TIMEOUT = floor(CLK_HZ·SPAN_PCT/(697·100)) cycles becomes invalid. SPAN_PCT defaults to 120. A 350 Hz / 440 Hz pair never produces early-steering.
- R6: `est` is high exactly while both bands are valid and the pair is not an inhibited letter key. It falls in the same cycle that a band loses validity.
- R7: Key code mapping, by low-band row (697, 770, 852, 941 Hz) and high-band column (1209, 1336, 1477, 1633 Hz):
  - Rows 1 to 3 read `1 2 3 A`, `4 5 6 B`, `7 8 9 C`; row 4 reads `* 0 #  D`.
  - Digits 1–9 give codes 1–9, `0` gives 10, `*` gives 11 and `#` gives 12.
  - A, B and C give 13, 14 and 15; D gives 0.
- R8: While `inhibit` is high, a pair in the 1633 Hz column does not raise `est` and leaves `key_code` unchanged. Digit keys are still decoded.
- R9: `key_code` loads on each rising clock edge at which `est` is high, and holds its value on every other edge.
- R10: A synchronous active-high `rst` clears both bands, drives `est` low and sets `key_code` to 0.
- R11: The period counters saturate at their maximum value instead of wrapping. After a silence longer than the counter range, a tone still decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference time base (nominal CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| lo_sq | input | 1 | Limited low-band square wave, synchronous to clk |
| hi_sq | input | 1 | Limited high-band square wave, synchronous to clk |
| inhibit | input | 1 | Suppresses the letter-key column |
| est | output | 1 | Early steering: both bands valid and not inhibited |
| key_code | output | 4 | Last decoded key code |

## Verification
The assertions assume that both square waves are already synchronous to `clk`, since a rising edge is taken from a single input register. The bench drives the waves and `inhibit` on the falling edge, one nanosecond after it. Every period it produces is a whole number of cycles, away from the window edges and away from the silence timeout, so rounding cannot move a case to the other side of a bound. The bench's reference model measures the actual input edges rather than the intended frequencies, so its expectations stay correct even where a period change leaves a short first period.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_HUNT = 2'd1,
        TRK_LOCK = 2'd2
    } trk_state_e;

    // Nominal tone in Hz; group 0 is the low band, group 1 the high band.
    function automatic longint tone_hz(input bit high_grp, input int idx);
        longint f;
        case ({high_grp, idx[1:0]})
            3'b000:  f = 697;
            3'b001:  f = 770;
            3'b010:  f = 852;
            3'b011:  f = 941;
            3'b100:  f = 1209;
            3'b101:  f = 1336;
            3'b110:  f = 1477;
            default: f = 1633;
        endcase
        return f;
    endfunction

    // Shortest accepted period count (ceiling).
    function automatic longint win_lo(input longint clk_hz, input longint f, input longint tol_pm);
        longint num;
        longint den;
        num = clk_hz * 1000;
        den = f * (1000 + tol_pm);
        return (num + den - 1) / den;
    endfunction

    // Longest accepted period count (floor).
    function automatic longint win_hi(input longint clk_hz, input longint f, input longint tol_pm);
        return (clk_hz * 1000) / (f * (1000 - tol_pm));
    endfunction

    // Keypad code from row (low band) and column (high band).
    function automatic logic [3:0] key_of(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] k;
        if (col == 2'd3) begin
            case (row)
                2'd0:    k = 4'd13;
                2'd1:    k = 4'd14;
                2'd2:    k = 4'd15;
                default: k = 4'd0;
            endcase
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    k = 4'd11;
                2'd1:    k = 4'd10;
                default: k = 4'd12;
            endcase
        end else begin
            k = 4'(row * 3 + col + 1);
        end
        return k;
    endfunction

endpackage

// File: rtl/dtmf_window_bank.sv
module dtmf_window_bank
    import dtmf_cls_pkg::*;
#(
    parameter longint CLK_HZ   = 3579545,
    parameter int     TOL_PM   = 25,
    parameter bit     HIGH_GRP = 1'b0,
    parameter int     CW       = 13
) (
    input  logic [CW-1:0] period,
    output logic          hit,
    output logic [1:0]    bin
);

    localparam int NWIN = 4;

    logic [NWIN-1:0] in_win;

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        localparam longint F_HZ = tone_hz(HIGH_GRP, k);
        localparam longint P_LO = win_lo(CLK_HZ, F_HZ, TOL_PM);
        localparam longint P_HI = win_hi(CLK_HZ, F_HZ, TOL_PM);
        assign in_win[k] = (longint'(period) >= P_LO) && (longint'(period) <= P_HI);
    end

    always_comb begin
        hit = |in_win;
        bin = 2'd0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (in_win[i]) bin = 2'(i);
        end
    end

endmodule

// File: rtl/dtmf_group_tracker.sv
module dtmf_group_tracker
    import dtmf_cls_pkg::*;
#(
    parameter longint CLK_HZ   = 3579545,
    parameter int     TOL_PM   = 25,
    parameter bit     HIGH_GRP = 1'b0,
    parameter int     LOCK_RUN = 4,
    parameter int     SPAN_PCT = 120
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sq,
    output logic       valid,
    output logic [1:0] bin
);

    localparam longint TIMEOUT = (CLK_HZ * SPAN_PCT) / (tone_hz(1'b0, 0) * 100);
    localparam int     CW      = $clog2(TIMEOUT + 2);
    localparam int     RW      = $clog2(LOCK_RUN + 1);
    localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
    localparam logic [CW-1:0] TMO_CNT  = CW'(TIMEOUT);
    localparam logic [RW:0]   RUN_GOAL = (RW + 1)'(LOCK_RUN);

    trk_state_e      state_q, state_d;
    logic            sq_q;
    logic            rise;
    logic [CW-1:0]   cnt_q;
    logic [RW-1:0]   run_q, run_d;
    logic [1:0]      bin_q, bin_d;
    logic            hit;
    logic [1:0]      win_bin;
    logic [RW:0]     run_up, run_cand;
    logic            same_win;
    logic            silent;

    dtmf_window_bank #(
        .CLK_HZ   (CLK_HZ),
        .TOL_PM   (TOL_PM),
        .HIGH_GRP (HIGH_GRP),
        .CW       (CW)
    ) u_win (
        .period (cnt_q),
        .hit    (hit),
        .bin    (win_bin)
    );

    assign rise   = sq & ~sq_q;
    assign silent = !rise && (cnt_q >= TMO_CNT);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TRK_IDLE;
        else     state_q <= state_d;
    end

    // Next state and run bookkeeping
    always_comb begin
        state_d  = state_q;
        run_d    = run_q;
        bin_d    = bin_q;
        same_win = (run_q != '0) && (win_bin == bin_q);
        run_up   = {1'b0, run_q} + 1'b1;
        if (!same_win)             run_cand = (RW + 1)'(1);
        else if (run_up > RUN_GOAL) run_cand = RUN_GOAL;
        else                        run_cand = run_up;
        unique case (state_q)
            TRK_IDLE: begin
                run_d = '0;
                if (rise) state_d = TRK_HUNT;
            end
            TRK_HUNT, TRK_LOCK: begin
                if (rise) begin
                    if (!hit) begin
                        run_d   = '0;
                        state_d = TRK_HUNT;
                    end else begin
                        run_d   = run_cand[RW-1:0];
                        bin_d   = win_bin;
                        state_d = (run_cand >= RUN_GOAL) ? TRK_LOCK : TRK_HUNT;
                    end
                end else if (silent) begin
                    run_d   = '0;
                    state_d = TRK_IDLE;
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    // Period counter and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q  <= 1'b0;
            cnt_q <= '0;
            run_q <= '0;
            bin_q <= 2'd0;
        end else begin
            sq_q  <= sq;
            run_q <= run_d;
            bin_q <= bin_d;
            if (rise)                cnt_q <= CW'(1);
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        valid = (state_q == TRK_LOCK);
        bin   = bin_q;
    end

    p_lock_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(rise));

    p_miss_drops_r4: assert property (@(posedge clk) disable iff (rst)
        (rise && !hit) |=> !valid);

    p_silence_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (!rise && cnt_q >= TMO_CNT) |=> !valid);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        (!rise && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder
    import dtmf_cls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lo_valid,
    input  logic [1:0] lo_bin,
    input  logic       hi_valid,
    input  logic [1:0] hi_bin,
    input  logic       inhibit,
    output logic       est,
    output logic [3:0] key_code
);

    logic letter;

    always_comb begin
        letter = (hi_bin == 2'd3);
        est    = lo_valid && hi_valid && !(inhibit && letter);
    end

    always_ff @(posedge clk) begin
        if (rst)      key_code <= 4'd0;
        else if (est) key_code <= key_of(lo_bin, hi_bin);
    end

    p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(est) |-> $stable(key_code));

    p_inhibit_no_letter_r8: assert property (@(posedge clk) disable iff (rst)
        (inhibit && est) |=> (key_code != 4'd0 && key_code < 4'd13));

    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (key_code == 4'd0 && !est));

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter longint CLK_HZ   = 3579545,
    parameter int     TOL_PM   = 25,
    parameter int     LOCK_RUN = 4,
    parameter int     SPAN_PCT = 120
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lo_sq,
    input  logic       hi_sq,
    input  logic       inhibit,
    output logic       est,
    output logic [3:0] key_code
);

    localparam int NGRP = 2;

    logic [NGRP-1:0] grp_valid;
    logic [1:0]      grp_bin [NGRP];
    logic [NGRP-1:0] grp_sq;

    assign grp_sq = {hi_sq, lo_sq};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        dtmf_group_tracker #(
            .CLK_HZ   (CLK_HZ),
            .TOL_PM   (TOL_PM),
            .HIGH_GRP (g == 1),
            .LOCK_RUN (LOCK_RUN),
            .SPAN_PCT (SPAN_PCT)
        ) u_trk (
            .clk   (clk),
            .rst   (rst),
            .sq    (grp_sq[g]),
            .valid (grp_valid[g]),
            .bin   (grp_bin[g])
        );
    end

    dtmf_key_encoder u_enc (
        .clk      (clk),
        .rst      (rst),
        .lo_valid (grp_valid[0]),
        .lo_bin   (grp_bin[0]),
        .hi_valid (grp_valid[1]),
        .hi_bin   (grp_bin[1]),
        .inhibit  (inhibit),
        .est      (est),
        .key_code (key_code)
    );

endmodule

// File: tb/tb_dtmf_pair_classifier.sv
module tb_dtmf_pair_classifier;

    localparam longint CLK_HZ   = 357954;
    localparam int     TOL_PM   = 25;
    localparam int     LOCK_RUN = 4;
    localparam int     SPAN_PCT = 120;
    localparam int     TMO      = int'((CLK_HZ * 12) / (697 * 10));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lo_sq = 1'b0;
    logic hi_sq = 1'b0;
    logic inhibit = 1'b0;
    logic est;
    logic [3:0] key_code;

    always #5 clk = ~clk;

    dtmf_pair_classifier #(
        .CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .LOCK_RUN(LOCK_RUN), .SPAN_PCT(SPAN_PCT)
    ) dut (
        .clk(clk), .rst(rst), .lo_sq(lo_sq), .hi_sq(hi_sq),
        .inhibit(inhibit), .est(est), .key_code(key_code)
    );

    int n_tests = 0;
    int n_fail = 0;
    int shown = 0;
    int wd = 0;
    bit est_seen = 0;
    bit est_low_seen = 0;

    real LOF [4] = '{697.0, 770.0, 852.0, 941.0};
    real HIF [4] = '{1209.0, 1336.0, 1477.0, 1633.0};

    // stimulus generators
    int lo_per = 0, lo_ph = 0, hi_per = 0, hi_ph = 0;

    // reference model
    int cyc = 0;
    int m_prev [2];
    int m_have [2];
    int m_last [2];
    int m_h [2][4];
    int m_n [2];
    logic [3:0] m_code = 4'd0;

    function automatic int classify(int g, int p);
        for (int k = 0; k < 4; k++) begin
            real f;
            real lo;
            real hi;
            f  = g ? HIF[k] : LOF[k];
            lo = real'(CLK_HZ) / (f * 1.025);
            hi = real'(CLK_HZ) / (f * 0.975);
            if (real'(p) >= lo && real'(p) <= hi) return k;
        end
        return -1;
    endfunction

    function automatic bit m_valid(int g);
        if (m_n[g] < 4 || m_h[g][3] < 0) return 1'b0;
        for (int i = 0; i < 3; i++) if (m_h[g][i] != m_h[g][3]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit m_est();
        return m_valid(0) && m_valid(1) && !(inhibit && m_h[1][3] == 3);
    endfunction

    function automatic logic [3:0] keymap(int r, int c);
        string s;
        byte ch;
        s  = "123A456B789C*0#D";
        ch = s[r * 4 + c];
        case (ch)
            "0": return 4'd10;
            "*": return 4'd11;
            "#": return 4'd12;
            "A": return 4'd13;
            "B": return 4'd14;
            "C": return 4'd15;
            "D": return 4'd0;
            default: return 4'(ch - "0");
        endcase
    endfunction

    task automatic m_step(int g, bit s);
        bit r;
        r = s && (m_prev[g] == 0);
        m_prev[g] = s;
        if (r) begin
            if (m_have[g] != 0) begin
                for (int i = 0; i < 3; i++) m_h[g][i] = m_h[g][i + 1];
                m_h[g][3] = classify(g, cyc - m_last[g]);
                if (m_n[g] < 4) m_n[g]++;
            end
            m_have[g] = 1;
            m_last[g] = cyc;
        end else if (m_have[g] != 0 && (cyc - m_last[g]) >= TMO) begin
            m_have[g] = 0;
            m_n[g] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < 2; g++) begin
                m_prev[g] = 0; m_have[g] = 0; m_last[g] = 0; m_n[g] = 0;
                for (int i = 0; i < 4; i++) m_h[g][i] = -1;
            end
            m_code = 4'd0;
            cyc = 0;
        end else begin
            if (m_est()) m_code = keymap(m_h[0][3], m_h[1][3]);
            m_step(0, lo_sq);
            m_step(1, hi_sq);
            cyc++;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (est !== m_est() || key_code !== m_code) begin
                n_fail++;
                if (shown < 8)
                    $display("FAIL R6 R9 model compare cycle %0d: est=%0b code=%0d expected est=%0b code=%0d",
                             cyc, est, key_code, m_est(), m_code);
                shown++;
            end
            if (est) est_seen = 1'b1;
            else     est_low_seen = 1'b1;
        end
        lo_sq = (lo_per > 0) && (lo_ph < lo_per / 2);
        lo_ph = (lo_per > 0) ? (lo_ph + 1) % lo_per : 0;
        hi_sq = (hi_per > 0) && (hi_ph < hi_per / 2);
        hi_ph = (hi_per > 0) ? (hi_ph + 1) % hi_per : 0;
        wd++;
        if (wd > 190000) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=%0d cycles expected<190000", wd);
            summary();
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int per_of(real f);
        return (f > 0.0) ? $rtoi(real'(CLK_HZ) / f + 0.5) : 0;
    endfunction

    task automatic set_tone(real fl, real fh);
        lo_per = per_of(fl); lo_ph = 0;
        hi_per = per_of(fh); hi_ph = 0;
    endtask

    task automatic tone(real fl, real fh, int dur);
        set_tone(fl, fh);
        step(dur);
    endtask

    task automatic quiet(int dur);
        set_tone(0.0, 0.0);
        step(dur);
    endtask

    initial begin
        rst = 1'b1;
        step(5);
        chk("R10 est after reset", int'(est), 0);
        chk("R10 code after reset", int'(key_code), 0);
        rst = 1'b0;
        step(2);

        // R3: no lock before four periods, lock afterwards
        set_tone(697.0, 1209.0);
        step(1900);
        chk("R3 est before fourth period", int'(est), 0);
        step(500);
        chk("R3 est after lock", int'(est), 1);
        chk("R7 code for 1", int'(key_code), 1);

        // R4: one short period drops, then relock (R3)
        est_low_seen = 1'b0;
        lo_per = 300;
        step(310);
        lo_per = per_of(697.0);
        step(2900);
        chk("R4 dropout cleared est", int'(est_low_seen), 1);
        chk("R3 relock after dropout", int'(est), 1);
        quiet(800);
        chk("R5 silence clears est", int'(est), 0);
        chk("R9 code held after tone", int'(key_code), 1);

        // R11: silence beyond the counter range
        quiet(1500);
        tone(697.0, 1336.0, 3300);
        chk("R11 decode after long silence", int'(key_code), 2);
        quiet(800);

        // R7, R6, R9: full keypad
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                tone(LOF[r], HIF[c], 3300);
                chk("R6 est during tone", int'(est), 1);
                chk("R7 key code", int'(key_code), int'(keymap(r, c)));
                quiet(800);
                chk("R6 est after tone", int'(est), 0);
                chk("R9 code holds", int'(key_code), int'(keymap(r, c)));
            end
        end

        // R1: accept edges
        tone(697.0 * 1.015 + 2.0, 1633.0 * 1.015 + 2.0, 3300);
        chk("R1 accept high side", int'(key_code), 13);
        quiet(800);
        tone(941.0 * 0.985 - 2.0, 1209.0 * 0.985 - 2.0, 3300);
        chk("R1 accept low side", int'(key_code), 11);
        quiet(800);
        tone(852.0 * 1.015 + 2.0, 1477.0 * 0.985 - 2.0, 3300);
        chk("R1 accept mixed", int'(key_code), 9);
        quiet(800);

        // R2: reject
        est_seen = 1'b0;
        tone(770.0 * 1.035, 1336.0, 3300);
        chk("R2 low +3.5% rejected", int'(est_seen), 0);
        quiet(800);
        est_seen = 1'b0;
        tone(852.0 * 0.965, 1477.0, 3300);
        chk("R2 low -3.5% rejected", int'(est_seen), 0);
        quiet(800);
        est_seen = 1'b0;
        tone(697.0, 1209.0 * 1.04, 3300);
        chk("R2 high +4% rejected", int'(est_seen), 0);
        chk("R2 code unchanged", int'(key_code), 9);
        quiet(800);

        // R5: dial tone pair
        est_seen = 1'b0;
        tone(350.0, 440.0, 3300);
        chk("R5 dial tone ignored", int'(est_seen), 0);
        quiet(800);

        // R8: inhibit
        tone(770.0, 1336.0, 3300);
        chk("R8 setup code 5", int'(key_code), 5);
        quiet(800);
        inhibit = 1'b1;
        est_seen = 1'b0;
        tone(770.0, 1633.0, 3300);
        chk("R8 letter blocked est", int'(est_seen), 0);
        chk("R8 letter keeps code", int'(key_code), 5);
        quiet(800);
        tone(852.0, 1477.0, 3300);
        chk("R8 digit under inhibit est", int'(est), 1);
        chk("R8 digit under inhibit code", int'(key_code), 9);
        quiet(800);
        inhibit = 1'b0;
        tone(941.0, 1633.0, 3300);
        chk("R8 letter D after inhibit", int'(key_code), 0);
        quiet(800);

        summary();
        $finish;
    end

endmodule